// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flagged Character FIFO

This block turns an asynchronous serial line into a queue of received characters. It runs from the system clock and advances its bit timing on a tick pulse supplied at sixteen times the bit rate. A falling edge that follows a high line is taken as a candidate start bit. The start bit is confirmed at its middle. Every later bit of the frame is sampled at its centre, and the frame ends with one stop bit.

Each character enters a 16-entry queue as a 10-bit word. The word carries the character's own parity and stop-bit errors, so software always reads the error next to the character that caused it. The block also reports a queue overrun, a half-full level and an idle timeout. The timeout counts whole character times during which nothing arrives while data is waiting. Any status bit can drive the interrupt output once its enable bit is set. Reads are one-cycle pulses, and the read word comes from a register.

Top module: `srx_top`

## Requirements
- R1: With `mode_i` = 1 (and also for the unused codes 0, 2 and 6) a frame has 8 data bits, least significant first, and no parity bit. The stored word is {1'b0 stop error, 1'b0, data[7:0]}, so bit 8 is 0.
- R2: With `mode_i` = 3 a frame has 7 data bits followed by a parity bit. The stored word holds the data in bits 6:0, with bit 7 = 0 and bit 8 = parity error.
- R3: For parity frames (`mode_i` = 3, or `mode_i` = 7 with 8 data bits plus parity), bit 8 of the stored word is 1 exactly when the parity check fails. Parity is even when `odd_par_i` = 0 and odd when it is 1.
- R4: With `mode_i` = 4 (9 data bits) or 5 (8 data bits plus a wake-up bit), the 9 bits received are stored in bits 8:0, and bit 8 of the head word does not raise the parity status bit.
- R5: Bit 9 of the stored word is 1 when the stop bit is sampled low. A break, where the line is held low for a whole frame, is stored as 10'h200 (in mode 1).
- R6: The queue holds 16 words in arrival order. A one-cycle `rd_i` pulse while the queue is not empty removes the head word and places it on `rd_data_o` after the next clock edge.
- R7: `status_o` has the following bits: bit 0 = queue not empty, bit 3 = head word's parity flag (parity modes only), bit 4 = head word's stop-error flag, bit 5 = overrun, bit 7 = timeout, bit 8 = half full. All other bits are 0, and all bits are 0 after reset.
- R8: A character that completes while the queue is full is discarded and sets the overrun bit. The overrun bit is cleared by the next read of a word.
- R9: The half-full bit is 1 when the queue holds 8 or more words.
- R10: When `idle_limit_i` is not 0 and the queue is not empty, the timeout bit rises after `idle_limit_i` character times (160 ticks each) pass with no new character. A read, a new character or a flush clears it.
- R11: A one-cycle `flush_i` pulse empties the queue and clears the overrun and timeout bits.
- R12: Characters are received only while both `rx_en_i` and `run_i` are 1. A frame sent at any other time leaves the queue unchanged.
- R13: `irq_o` is 1 exactly when at least one bit of `status_o` is 1 and the same bit of `int_en_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial input line, idle high |
| tick_i | input | 1 | Single-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Receive enable |
| run_i | input | 1 | Block run control |
| mode_i | input | 3 | Frame mode code |
| odd_par_i | input | 1 | Selects odd parity when 1 and even parity when 0 |
| idle_limit_i | input | 8 | Idle timeout in character times; 0 disables the timeout |
| flush_i | input | 1 | Empties the queue |
| rd_i | input | 1 | Pops the head word |
| int_en_i | input | 9 | Interrupt enable, one bit per status bit |
| rd_data_o | output | 10 | Last word popped: {stop error, parity flag or ninth bit, data} |
| status_o | output | 9 | Status flags |
| irq_o | output | 1 | Interrupt request |

## Verification
If the bit counter or the sampling phase goes wrong, a misaligned word shows on `rd_data_o` at the first read after the frame: shifted data, a false parity flag or a false stop error. Faults in the queue pointers show up as words out of order, as a half-full or overrun bit at the wrong fill level, or as a not-empty bit that does not follow reads. These are seen within one cycle of the pop. Faults in the idle timer show as a timeout bit that is early, late or stuck, and this is visible within one character time of the limit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned STAT_W = 9;

  localparam logic [2:0] MODE_D8   = 3'd1;
  localparam logic [2:0] MODE_D7P  = 3'd3;
  localparam logic [2:0] MODE_D9   = 3'd4;
  localparam logic [2:0] MODE_D8W  = 3'd5;
  localparam logic [2:0] MODE_D8P  = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} rx_state_e;

  function automatic logic has_parity(input logic [2:0] m);
    return (m == MODE_D7P) || (m == MODE_D8P);
  endfunction

  // bits between start and stop
  function automatic logic [3:0] frame_bits(input logic [2:0] m);
    return (m == MODE_D8P || m == MODE_D9 || m == MODE_D8W) ? 4'd9 : 4'd8;
  endfunction
endpackage

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              active_i,
  input  logic [2:0]        mode_i,
  input  logic              odd_par_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic            rxd_m, rxd_s, armed;
  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [3:0]      idx;
  logic [8:0]      sh;
  logic [WORD_W-1:0] asm_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd_i;
      rxd_s <= rxd_m;
    end
  end

  always_comb begin
    asm_w = '0;
    asm_w[9] = ~rxd_s;
    unique case (mode_i)
      MODE_D7P: begin
        asm_w[6:0] = sh[6:0];
        asm_w[8]   = (^sh[7:0]) ^ odd_par_i;
      end
      MODE_D8P: begin
        asm_w[7:0] = sh[7:0];
        asm_w[8]   = (^sh[8:0]) ^ odd_par_i;
      end
      MODE_D9, MODE_D8W: asm_w[8:0] = sh;
      default: asm_w[7:0] = sh[7:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      armed <= 1'b0; push_o <= 1'b0; word_o <= '0;
    end else if (!active_i) begin
      st <= S_IDLE; armed <= 1'b0; push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (rxd_s) armed <= 1'b1;
          else if (tick_i && armed) begin
            st <= S_START; cnt <= '0; armed <= 1'b0;
          end
        end
        S_START: if (tick_i) begin
          if (cnt == MID) begin
            cnt <= '0; idx <= '0; sh <= '0;
            st  <= rxd_s ? S_IDLE : S_BITS;
          end else cnt <= cnt + 1'b1;
        end
        S_BITS: if (tick_i) begin
          if (cnt == LAST) begin
            cnt <= '0;
            sh[idx] <= rxd_s;
            if (idx == frame_bits(mode_i) - 4'd1) st <= S_STOP;
            else idx <= idx + 4'd1;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick_i) begin
          if (cnt == LAST) begin
            push_o <= 1'b1;
            word_o <= asm_w;
            armed  <= rxd_s;
            st     <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               din_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       ovr_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_pop, do_push;

  assign full    = (count_o == (AW+1)'(DEPTH));
  assign empty   = (count_o == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign head_o  = mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; count_o <= '0; ovr_o <= 1'b0; dout_o <= '0;
    end else if (flush_i) begin
      wp <= '0; rp <= '0; count_o <= '0; ovr_o <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop) begin
        rp     <= rp + 1'b1;
        dout_o <= mem[rp];
      end
      count_o <= count_o + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (do_pop)                ovr_o <= 1'b0;
      else if (push_i && full)   ovr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
  parameter int unsigned CHAR_TICKS = 160,
  parameter int unsigned LIM_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             empty_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             to_o
);
  localparam int unsigned TW = $clog2(CHAR_TICKS);

  logic [TW-1:0]    tcnt;
  logic [LIM_W-1:0] ccnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt <= '0; ccnt <= '0; to_o <= 1'b0;
    end else if (restart_i || empty_i) begin
      tcnt <= '0; ccnt <= '0; to_o <= 1'b0;
    end else if (!to_o && limit_i != '0) begin
      if (ccnt == limit_i) to_o <= 1'b1;
      else if (tick_i) begin
        if (tcnt == TW'(CHAR_TICKS - 1)) begin
          tcnt <= '0;
          ccnt <= ccnt + 1'b1;
        end else tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned OSR        = 16,
  parameter int unsigned CHAR_TICKS = 160,
  parameter int unsigned LIM_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              run_i,
  input  logic [2:0]        mode_i,
  input  logic              odd_par_i,
  input  logic [LIM_W-1:0]  idle_limit_i,
  input  logic              flush_i,
  input  logic              rd_i,
  input  logic [STAT_W-1:0] int_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  logic              active, push, ovr, to_flag, empty;
  logic [WORD_W-1:0] word, head;
  logic [CNT_W-1:0]  count;

  assign active = rx_en_i && run_i;
  assign empty  = (count == '0);

  srx_framer #(.OSR(OSR)) u_framer (
    .clk_i, .rst_ni, .rxd_i, .tick_i,
    .active_i (active),
    .mode_i, .odd_par_i,
    .push_o   (push),
    .word_o   (word)
  );

  srx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i,
    .push_i  (push),
    .din_i   (word),
    .pop_i   (rd_i),
    .head_o  (head),
    .dout_o  (rd_data_o),
    .count_o (count),
    .ovr_o   (ovr)
  );

  srx_idle_timer #(.CHAR_TICKS(CHAR_TICKS), .LIM_W(LIM_W)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .restart_i (push || flush_i || (rd_i && !empty)),
    .empty_i   (empty),
    .limit_i   (idle_limit_i),
    .to_o      (to_flag)
  );

  always_comb begin
    status_o    = '0;
    status_o[0] = !empty;
    status_o[3] = !empty && head[8] && has_parity(mode_i);
    status_o[4] = !empty && head[9];
    status_o[5] = ovr;
    status_o[7] = to_flag;
    status_o[8] = (count >= CNT_W'(DEPTH/2));
  end

  assign irq_o = |(status_o & int_en_i);
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             flush_i,
  input logic             active,
  input logic             push,
  input logic [CNT_W-1:0] count,
  input logic [8:0]       status_o
);
  // R6
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  // R8
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && status_o[0] && !flush_i) |=> !status_o[5]);

  // R11
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!status_o[0] && !status_o[5] && !status_o[7]));

  // R10
  timeout_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |-> status_o[0]);

  // R12
  gated_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && $past(!active)) |-> !push);

  // R9
  half_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[8] |-> status_o[0]);
endmodule

bind srx_top srx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .rd_i, .flush_i, .active, .push, .count, .status_o
);

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       rx_en_i = 1'b1, run_i = 1'b1;
  logic [2:0] mode_i = 3'd1;
  logic       odd_par_i = 1'b0;
  logic [7:0] idle_limit_i = '0;
  logic       flush_i = 1'b0, rd_i = 1'b0;
  logic [8:0] int_en_i = '0;
  logic [9:0] rd_data_o;
  logic [8:0] status_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  logic [1:0] div = '0;

  always #4 clk_i = ~clk_i;

  always_ff @(posedge clk_i) begin
    div    <= div + 2'd1;
    tick_i <= (div == 2'd3);
  end

  srx_top dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) begin
      @(posedge clk_i);
      while (!tick_i) @(posedge clk_i);
    end
    @(negedge clk_i);
  endtask

  // bits sent LSB first, n bits between start and stop
  task automatic send(input logic [8:0] bits, input int n, input logic stopv);
    rxd_i = 1'b0; wt(16);
    for (int i = 0; i < n; i++) begin
      rxd_i = bits[i]; wt(16);
    end
    rxd_i = stopv; wt(16);
    rxd_i = 1'b1; wt(4);
  endtask

  task automatic pop(output logic [9:0] w);
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    w = rd_data_o;
  endtask

  task automatic t_reset();
    check("R7 reset status", status_o, 9'h000);
    check("R13 reset irq", irq_o, 1'b0);
    check("R6 reset rd_data", rd_data_o, 10'h000);
  endtask

  task automatic t_mode8();
    logic [9:0] w;
    mode_i = 3'd1; send(9'h0A5, 8, 1'b1);
    check("R7 not empty", status_o[0], 1'b1);
    pop(w); check("R1 mode1 word", w, 10'h0A5);
    check("R6 empty after read", status_o[0], 1'b0);
    mode_i = 3'd0; send(9'h03C, 8, 1'b1);
    pop(w); check("R1 mode0 as 8 bit", w, 10'h03C);
    mode_i = 3'd1;
  endtask

  task automatic t_parity();
    logic [9:0] w;
    mode_i = 3'd3; odd_par_i = 1'b0;
    send({1'b0, 1'b0, 7'h35}, 8, 1'b1);
    pop(w); check("R2 7bit even ok", w, 10'h035);
    send({1'b0, 1'b1, 7'h35}, 8, 1'b1);
    check("R7 parity status bit3", status_o[3], 1'b1);
    pop(w); check("R3 7bit even bad", w, 10'h135);
    odd_par_i = 1'b1;
    send({1'b0, 1'b1, 7'h35}, 8, 1'b1);
    pop(w); check("R3 7bit odd ok", w, 10'h035);
    mode_i = 3'd7; odd_par_i = 1'b0;
    send({1'b0, 8'h0F}, 9, 1'b1);
    pop(w); check("R3 8bit even ok", w, 10'h00F);
    send({1'b1, 8'h0F}, 9, 1'b1);
    pop(w); check("R3 8bit even bad", w, 10'h10F);
    mode_i = 3'd1;
  endtask

  task automatic t_nine();
    logic [9:0] w;
    mode_i = 3'd4; send(9'h1A5, 9, 1'b1);
    check("R4 bit8 not parity", status_o[3], 1'b0);
    pop(w); check("R4 mode4 word", w, 10'h1A5);
    mode_i = 3'd5; send(9'h155, 9, 1'b1);
    pop(w); check("R4 mode5 word", w, 10'h155);
    mode_i = 3'd1; send(9'h1FF, 8, 1'b1);
    pop(w); check("R1 bit8 zero", w, 10'h0FF);
  endtask

  task automatic t_frame();
    logic [9:0] w;
    send(9'h05A, 8, 1'b0);
    check("R7 frame status bit4", status_o[4], 1'b1);
    pop(w); check("R5 stop error", w, 10'h25A);
    send(9'h000, 8, 1'b0);
    pop(w); check("R5 break", w, 10'h200);
  endtask

  task automatic t_irq();
    logic [9:0] w;
    send(9'h011, 8, 1'b1);
    int_en_i = 9'h000; @(negedge clk_i);
    check("R13 masked", irq_o, 1'b0);
    int_en_i = 9'h001; @(negedge clk_i);
    check("R13 enabled", irq_o, 1'b1);
    int_en_i = 9'h000;
    pop(w);
  endtask

  task automatic t_fill();
    logic [9:0] w;
    for (int i = 0; i < 7; i++) send(9'(i), 8, 1'b1);
    check("R9 below half", status_o[8], 1'b0);
    send(9'd7, 8, 1'b1);
    check("R9 at half", status_o[8], 1'b1);
    for (int i = 8; i < 16; i++) send(9'(i), 8, 1'b1);
    check("R8 no overrun when full", status_o[5], 1'b0);
    send(9'h0EE, 8, 1'b1);
    check("R8 overrun set", status_o[5], 1'b1);
    pop(w); check("R6 order first", w, 10'h000);
    check("R8 overrun cleared", status_o[5], 1'b0);
    for (int i = 1; i < 16; i++) begin
      pop(w); check("R6 order", w, 10'(i));
    end
    check("R8 extra discarded", status_o[0], 1'b0);
  endtask

  task automatic t_timeout();
    logic [9:0] w;
    idle_limit_i = 8'd2; int_en_i = 9'h080;
    send(9'h042, 8, 1'b1);
    wt(160);
    check("R10 not yet", status_o[7], 1'b0);
    wt(200);
    check("R10 raised", status_o[7], 1'b1);
    check("R13 timeout irq", irq_o, 1'b1);
    pop(w);
    check("R10 cleared by read", status_o[7], 1'b0);
    idle_limit_i = '0; int_en_i = '0;
  endtask

  task automatic t_flush();
    send(9'h001, 8, 1'b1);
    send(9'h002, 8, 1'b1);
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
    check("R11 flushed", status_o, 9'h000);
  endtask

  task automatic t_gate();
    logic [9:0] w;
    run_i = 1'b0; send(9'h077, 8, 1'b1);
    check("R12 run low", status_o[0], 1'b0);
    run_i = 1'b1; rx_en_i = 1'b0; send(9'h077, 8, 1'b1);
    check("R12 enable low", status_o[0], 1'b0);
    rx_en_i = 1'b1; wt(2); send(9'h066, 8, 1'b1);
    pop(w); check("R12 resumes", w, 10'h066);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    wt(4);
    t_mode8();
    t_parity();
    t_nine();
    t_frame();
    t_irq();
    t_fill();
    t_timeout();
    t_flush();
    t_gate();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule